// File: doc/BRIEF.md
# Shared-Bus Two-Channel Converter Input Stage

This block is the digital front end of a two-channel 8-bit converter whose channels share one data bus. The bus is read twice per clock period. On the falling edge it fills a holding latch that belongs to channel B. On the next rising edge it fills the channel A register, and in that same edge the held value moves into the channel B register. Both channel codes therefore change together on the rising edge. Channel B shows the word that was on the bus half a period before channel A's word. An active-low select decides whether either edge takes a word.

Two control pins set a power state. The block registers that state and drives an output-valid flag that stays low until a wake-up wait has run out. The wait is counted in clock cycles, and its length is computed from the clock frequency and two wake times given as parameters. The wait after a shutdown is the long one. The wait after standby is the short one. Codes are kept through every low-power state, so the outputs return with their last values.

Top module: `dual_dac_front`

## Requirements
- R1: The data bus is DW bits wide (8 by default). Bit 0 is the least significant bit and bit DW-1 the most significant. Codes are carried unchanged from bus to outputs.
- R2: On a rising edge where a capture is allowed, `code_a` takes the bus value present at that edge.
- R3: On a falling edge where a capture is allowed, the bus value goes into a holding latch. On the next rising edge where a capture is allowed, `code_b` takes the latch contents. `code_a` and `code_b` change on the same rising edge.
- R4: A capture is allowed on an edge only while `cs_n` is 0 and the block is in the active state at that edge. Otherwise the registers and the latch keep their values, even when the select differs between the two halves of a cycle.
- R5: Each rising edge registers the power state into `mode`. `pwr_down`=1 gives shutdown (2'b10) whatever `chan_en` is. `pwr_down`=0 with `chan_en`=0 gives standby (2'b01). `pwr_down`=0 with `chan_en`=1 gives active (2'b00).
- R6: `out_valid` is 0 whenever `mode` is standby or shutdown. Codes are held, not cleared, and return unchanged when the block is active again.
- R7: After standby, `out_valid` rises on the STBY_CYC-th consecutive rising edge that samples the active state. STBY_CYC = max(1, CLK_HZ/1e6 × STBY_NS/1000).
- R8: After a shutdown, `out_valid` rises only after SHDN_CYC such edges, computed the same way from SHDN_NS. Passing through standby on the way back does not shorten this wait. Leaving the active state before the wait ends restarts the count.
- R9: While `rst_n` is 0 at a clock edge, the block clears both codes and the latch to 0, sets `mode` to shutdown and `out_valid` to 0, and the next wake-up takes the long wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Select, active low; gates captures |
| bus_in | input | DW | Shared data bus carrying both channels |
| pwr_down | input | 1 | 1 = shutdown |
| chan_en | input | 1 | With pwr_down=0: 1 = active, 0 = standby |
| code_a | output | DW | Channel A code |
| code_b | output | DW | Channel B code |
| mode | output | 2 | 00 active, 01 standby, 10 shutdown |
| out_valid | output | 1 | Outputs enabled and settled |

## Verification
Two functions can act in the same cycle: the rising edge that ends the wake-up wait can also carry a dual-edge capture. The bench starts a bus transfer timed so that its rising edge is exactly the last edge of the wait. It then checks, in that cycle, that `out_valid` has just gone to 1 and that both codes already show the new pair. The cycle before is also checked, to confirm that the flag is not early. A second overlap is a select that is high for the falling edge and low for the rising edge. There, channel A must take its new word while channel B receives the older held word.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE   = 2'b00,
        MODE_STANDBY  = 2'b01,
        MODE_SHUTDOWN = 2'b10
    } pwr_mode_e;

    function automatic pwr_mode_e decode_mode(input logic pd, input logic en);
        if (pd)      return MODE_SHUTDOWN;
        else if (en) return MODE_ACTIVE;
        else         return MODE_STANDBY;
    endfunction

    function automatic int wake_cycles(input int clk_hz, input int ns);
        int c;
        c = ((clk_hz / 1000000) * ns) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
    import dac_fe_pkg::*;
#(
    parameter int STBY_CYC = 25,
    parameter int SHDN_CYC = 2500
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd,
    input  logic      en,
    output pwr_mode_e mode_o,
    output logic      run_o,
    output logic      valid_o
);
    localparam int CNT_W = $clog2(SHDN_CYC + 1);

    typedef struct packed {
        pwr_mode_e        mode;
        logic             deep;
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } seq_t;

    seq_t st_d, st_q;
    pwr_mode_e        pins_mode;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;

    assign pins_mode = decode_mode(pd, en);
    assign run_o     = (pins_mode == MODE_ACTIVE);
    assign limit     = st_q.deep ? CNT_W'(SHDN_CYC) : CNT_W'(STBY_CYC);
    assign cnt_inc   = st_q.cnt + 1'b1;

    always_comb begin
        st_d      = st_q;
        st_d.mode = pins_mode;
        if (pins_mode != MODE_ACTIVE) begin
            st_d.valid = 1'b0;
            st_d.cnt   = '0;
            if (pins_mode == MODE_SHUTDOWN) st_d.deep = 1'b1;
        end else if (!st_q.valid) begin
            st_d.cnt = cnt_inc;
            if (cnt_inc >= limit) begin
                st_d.valid = 1'b1;
                st_d.deep  = 1'b0;
                st_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_SHUTDOWN;
            st_q.deep  <= 1'b1;
            st_q.cnt   <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign valid_o = st_q.valid;

    p_shutdown_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (mode_o == MODE_SHUTDOWN));
    p_standby_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && !en) |=> (mode_o == MODE_STANDBY));
    p_valid_only_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (mode_o == MODE_ACTIVE));
    p_sleep_drops_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |=> !valid_o);
    p_cnt_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(SHDN_CYC));
endmodule

// File: rtl/dac_dual_capture.sv
module dac_dual_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          run,
    input  logic [DW-1:0] bus,
    output logic [DW-1:0] code_a_o,
    output logic [DW-1:0] code_b_o
);
    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } pair_t;

    pair_t         out_d, out_q;
    logic [DW-1:0] pre_d, pre_q;
    logic          take;

    assign take = !cs_n && run;

    always_comb begin
        pre_d = take ? bus : pre_q;
    end

    always_ff @(negedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    always_comb begin
        out_d = out_q;
        if (take) begin
            out_d.a = bus;
            out_d.b = pre_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign code_a_o = out_q.a;
    assign code_b_o = out_q.b;

    p_a_follows_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (code_a_o == $past(bus)));
    p_b_from_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (code_b_o == $past(pre_q)));
    p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(code_a_o) && $stable(code_b_o)));
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
    import dac_fe_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CLK_HZ  = 50000000,
    parameter int STBY_NS = 500,
    parameter int SHDN_NS = 50000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic [DW-1:0] bus_in,
    input  logic          pwr_down,
    input  logic          chan_en,
    output logic [DW-1:0] code_a,
    output logic [DW-1:0] code_b,
    output logic [1:0]    mode,
    output logic          out_valid
);
    localparam int STBY_CYC = wake_cycles(CLK_HZ, STBY_NS);
    localparam int SHDN_CYC = wake_cycles(CLK_HZ, SHDN_NS);

    pwr_mode_e mode_w;
    logic      run_w;

    dac_pwr_seq #(.STBY_CYC(STBY_CYC), .SHDN_CYC(SHDN_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd      (pwr_down),
        .en      (chan_en),
        .mode_o  (mode_w),
        .run_o   (run_w),
        .valid_o (out_valid)
    );

    dac_dual_capture #(.DW(DW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .run      (run_w),
        .bus      (bus_in),
        .code_a_o (code_a),
        .code_b_o (code_b)
    );

    assign mode = mode_w;
endmodule

// File: tb/dual_dac_front_test.sv
module dual_dac_front_test;
    localparam int CLK_HZ = 50000000;
    localparam int ST_NS  = 200;
    localparam int SD_NS  = 2000;
    localparam int LS     = (CLK_HZ / 1000000) * ST_NS / 1000;
    localparam int LD     = (CLK_HZ / 1000000) * SD_NS / 1000;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cs_n = 1;
    logic [7:0] bus_in = 0;
    logic       pwr_down = 1;
    logic       chan_en = 0;
    logic [7:0] code_a, code_b;
    logic [1:0] mode;
    logic       out_valid;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] last_a, last_b;

    always #10 clk = ~clk;

    dual_dac_front #(.DW(8), .CLK_HZ(CLK_HZ), .STBY_NS(ST_NS), .SHDN_NS(SD_NS)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bus_in(bus_in),
        .pwr_down(pwr_down), .chan_en(chan_en),
        .code_a(code_a), .code_b(code_b), .mode(mode), .out_valid(out_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Called just after a rising edge; ends 3 ns after the next rising edge.
    task automatic xfer(input logic [7:0] a, input logic [7:0] b,
                        input logic sel_fall, input logic sel_rise);
        cs_n = sel_fall; bus_in = b;
        @(negedge clk); #2;
        cs_n = sel_rise; bus_in = a;
        @(posedge clk); #3;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        edges(3);
        rst_n = 1;
        // R9: reset state
        chk("R9 code_a reset", code_a, 0);
        chk("R9 code_b reset", code_b, 0);
        chk("R9 mode reset", mode, 2);
        chk("R9 valid reset", out_valid, 0);

        // R8/R9: first wake after reset takes the long wait
        pwr_down = 0; chan_en = 1;
        edges(1);
        chk("R5 active mode", mode, 0);
        edges(LD - 2);
        chk("R8 not valid before long wait", out_valid, 0);
        edges(1);
        chk("R8 valid after long wait", out_valid, 1);

        // R1 R2 R3: exhaustive sweep of channel A, derived B pattern
        for (int i = 0; i < 256; i++) begin
            logic [7:0] bv;
            bv = 8'((i * 37 + 11) & 255);
            xfer(8'(i), bv, 1'b0, 1'b0);
            chk("R2 code_a", code_a, i);
            chk("R3 code_b", code_b, bv);
        end
        // R1: bit order, single bits walked across both channels
        for (int k = 0; k < 8; k++) begin
            xfer(8'(1 << k), 8'(8'h80 >> k), 1'b0, 1'b0);
            chk("R1 lsb-msb code_a", code_a, 1 << k);
            chk("R1 lsb-msb code_b", code_b, 8'h80 >> k);
        end
        xfer(8'h3C, 8'hC3, 1'b0, 1'b0);
        last_a = 8'h3C; last_b = 8'hC3;

        // R4: select high on both edges holds everything
        xfer(8'h11, 8'h22, 1'b1, 1'b1);
        chk("R4 hold a", code_a, last_a);
        chk("R4 hold b", code_b, last_b);
        // R4: high on fall, low on rise -> B gets older latched word
        xfer(8'h55, 8'h66, 1'b1, 1'b0);
        chk("R4 split a new", code_a, 8'h55);
        chk("R4 split b old latch", code_b, last_b);
        // R4: low on fall, high on rise -> nothing moves, latch updated
        xfer(8'h77, 8'h88, 1'b0, 1'b1);
        chk("R4 split2 a hold", code_a, 8'h55);
        chk("R4 split2 b hold", code_b, last_b);
        xfer(8'h99, 8'hAA, 1'b1, 1'b0);
        chk("R3 latch from earlier fall", code_b, 8'h88);
        chk("R2 a after split", code_a, 8'h99);
        last_a = 8'h99; last_b = 8'h88;

        // R5 R6: standby, captures ignored, codes held
        cs_n = 1; chan_en = 0;
        edges(1);
        chk("R5 standby mode", mode, 1);
        chk("R6 standby valid", out_valid, 0);
        xfer(8'hE1, 8'hE2, 1'b0, 1'b0);
        chk("R4 standby a held", code_a, last_a);
        chk("R4 standby b held", code_b, last_b);

        // R7: short wake, capture coinciding with valid rising
        cs_n = 1; chan_en = 1;
        edges(LS - 1);
        chk("R7 not valid before short wait", out_valid, 0);
        chk("R6 codes resumed a", code_a, last_a);
        chk("R6 codes resumed b", code_b, last_b);
        xfer(8'h5A, 8'hA5, 1'b0, 1'b0);
        chk("R7 valid after short wait", out_valid, 1);
        chk("R7 coincident capture a", code_a, 8'h5A);
        chk("R7 coincident capture b", code_b, 8'hA5);

        // R5: shutdown regardless of chan_en
        cs_n = 1; pwr_down = 1; chan_en = 1;
        edges(1);
        chk("R5 shutdown en=1", mode, 2);
        chk("R6 shutdown valid", out_valid, 0);
        chan_en = 0;
        edges(1);
        chk("R5 shutdown en=0", mode, 2);
        // R8: via standby still long wait
        pwr_down = 0;
        edges(2);
        chk("R5 standby after shutdown", mode, 1);
        chan_en = 1;
        edges(LS);
        chk("R8 standby does not shorten", out_valid, 0);
        // R8: interrupted wait restarts
        chan_en = 0;
        edges(1);
        chan_en = 1;
        edges(LD - 1);
        chk("R8 restart not yet valid", out_valid, 0);
        edges(1);
        chk("R8 restart valid", out_valid, 1);
        chk("R6 codes held through shutdown a", code_a, 8'h5A);
        chk("R6 codes held through shutdown b", code_b, 8'hA5);

        // R9: reset mid-operation
        rst_n = 0;
        edges(2);
        rst_n = 1;
        chk("R9 reset clears a", code_a, 0);
        chk("R9 reset clears b", code_b, 0);
        chk("R9 reset valid", out_valid, 0);
        edges(LS + 1);
        chk("R9 reset forces long wait", out_valid, 0);
        finish_run();
    end
endmodule